// File: doc/BRIEF.md
# Comparator Timer Channel

This block is one channel of a high-precision event timer. It watches a free-running 64-bit main counter that is supplied from outside. It holds a comparator, a period register and a five-bit configuration word, and it compares the counter against a hidden 64-bit target. When the counter reaches that target, the channel fires. Firing can set an interrupt-status bit and can drive an interrupt line, either as a held level or as a one-cycle pulse.

The channel works in one-shot or periodic mode, and compares either the full 64 bits or only the low 32 bits. In narrow mode the 32-bit comparator is placed onto the current counter value to form the hidden target. A narrow one-shot channel also fires once at the next 32-bit wrap of the counter when the real target lies beyond that wrap. In periodic mode each expiry moves the target forward by whole periods until it is ahead of the counter, so any missed periods are skipped.

A register interface drives the channel through single-cycle write strobes. It reads back the comparator and the configuration word. The status bit itself is held outside the block: the block sends it a set pulse and receives a clear strobe from it.

Top module: `tmr_channel`

## Requirements
- R1: In 32-bit mode (config bit 3 = 1), arming forms the target from the upper 32 bits of the counter and the low 32 bits of the comparator. If this value is below the counter, 2^32 is added to it.
- R2: In 64-bit mode the target is the full comparator. A one-shot channel fires once when the counter reaches the target and then stops until it is armed again.
- R3: In 32-bit one-shot mode (config bit 1 = 0), when the target lies beyond the next wrap point, the channel fires first at that point. The wrap point is the counter with its low 32 bits all ones, plus one. The channel then fires again at the target.
- R4: In periodic mode (config bit 1 = 1) with a nonzero period, an expiry adds the period to the target as many times as needed to bring it strictly above the counter. In 32-bit mode the readable comparator then takes the low 32 bits of the new target.
- R5: A comparator write changes the comparator only when the channel is one-shot or the set-value bit (config bit 4) is 1. In periodic mode the written value always goes into the period register. The set-value bit reads 0 after any accepted comparator write. Config bit 0 is the channel enable.
- R6: In 32-bit mode a write to the upper comparator half has no effect. A config write that sets 32-bit mode clears the upper halves of the comparator and the period.
- R7: An expiry pulses stat_set_o for one cycle only when config bit 2 (level mode) is 1, and it does so even when the channel enable is 0.
- R8: irq_o responds only when the channel enable and the global enable are both 1. In edge mode it is high for exactly the one cycle after the edge at which the counter reached the target.
- R9: A re-arm clears any pending wrap firing. Arming happens on a channel-enable rise while globally enabled, and on an accepted comparator write while globally enabled.
- R10: While the global enable is 0 nothing fires. A rise of the global enable re-arms the channel from its comparator.
- R11: In level mode irq_o stays high until sts_clr_i is pulsed. It also drops when the channel enable, the global enable or level mode is switched off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cnt_i | input | 64 | Main counter value |
| glob_en_i | input | 1 | Global enable |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_wdata_i | input | 5 | Config value: bit0 enable, bit1 periodic, bit2 level, bit3 32-bit, bit4 set-value |
| cmp_we_i | input | 1 | Comparator write strobe (ignored in a cycle with cfg_we_i) |
| cmp_hi_i | input | 1 | Comparator write selects the upper half |
| cmp_wdata_i | input | 32 | Comparator write data |
| sts_clr_i | input | 1 | Status-clear strobe, drops a level interrupt |
| cmp_rd_o | output | 64 | Readable comparator |
| cfg_rd_o | output | 5 | Readable configuration word |
| stat_set_o | output | 1 | Status-set pulse |
| irq_o | output | 1 | Interrupt line |

## Verification
Every result of this block appears one clock after the edge at which the stimulus is seen. This covers the write effects on the readback, the re-arm, the expiry's status pulse, the interrupt line and the periodic reload of the comparator. The bench therefore advances its own model at the same edge the design uses and compares all four outputs 2 ns after every rising edge. Directed checks on pulse counts and readback values are taken at falling edges, after the writes they depend on have settled, so none of them depends on the exact cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CFG_W = 5;

  // Configuration word; bit 0 is en, bit 4 is setval.
  typedef struct packed {
    logic setval;
    logic w32;
    logic level;
    logic per;
    logic en;
  } cfg_t;
endpackage

// File: rtl/tmr_arm_calc.sv
module tmr_arm_calc #(
  parameter int unsigned NAR_W = 32
) (
  input  logic [2*NAR_W-1:0] cmp_i,
  input  logic [2*NAR_W-1:0] cnt_i,
  input  logic               w32_i,
  input  logic               per_i,
  output logic [2*NAR_W-1:0] tgt_o,
  output logic [2*NAR_W-1:0] due_o,
  output logic               wrap_o
);
  localparam int unsigned CNT_W = 2 * NAR_W;
  localparam logic [CNT_W-1:0] SPAN = {{(CNT_W-1){1'b0}}, 1'b1} << NAR_W;
  localparam logic [CNT_W-1:0] LOW_ONES = SPAN - 1'b1;

  logic [CNT_W-1:0] placed;
  logic [CNT_W-1:0] wrap_pt;

  always_comb begin
    placed = {cnt_i[CNT_W-1:NAR_W], cmp_i[NAR_W-1:0]};
    if (placed < cnt_i) placed = placed + SPAN;
    wrap_pt = (cnt_i | LOW_ONES) + 1'b1;
    tgt_o   = w32_i ? placed : cmp_i;
    wrap_o  = w32_i && !per_i && (tgt_o > wrap_pt);
    due_o   = wrap_o ? wrap_pt : tgt_o;
  end

  // R1: a narrow target never lies at or beyond one full span past the counter
  always_comb begin
    if (w32_i) begin
      assert_narrow_window_R1: assert ((placed - cnt_i) < SPAN);
    end
  end
endmodule

// File: rtl/tmr_reload.sv
module tmr_reload #(
  parameter int unsigned CNT_W = 64
) (
  input  logic [CNT_W-1:0] tgt_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] tgt_o
);
  logic [CNT_W-1:0] lag;
  logic [CNT_W-1:0] div;
  logic [CNT_W-1:0] steps;

  always_comb begin
    lag   = cnt_i - tgt_i;
    div   = (per_i == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : per_i;
    steps = lag / div + 1'b1;
    tgt_o = tgt_i + steps * per_i;
  end
endmodule

// File: rtl/tmr_irq_out.sv
module tmr_irq_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic en_i,
  input  logic level_i,
  input  logic glob_en_i,
  input  logic clr_i,
  output logic stat_set_o,
  output logic irq_o
);
  logic stat_q, pulse_q, lvl_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      stat_q  <= 1'b0;
      pulse_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      stat_q  <= fire_i && level_i;
      pulse_q <= fire_i && en_i && !level_i;
      if (fire_i && en_i && level_i) lvl_q <= 1'b1;
      else if (clr_i || !glob_en_i || !en_i || !level_i) lvl_q <= 1'b0;
    end
  end

  assign stat_set_o = stat_q;
  assign irq_o      = pulse_q | lvl_q;

  assert_status_level_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_set_o |-> $past(level_i));

  assert_irq_needs_enables_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(glob_en_i && en_i));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned NAR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2*NAR_W-1:0]  cnt_i,
  input  logic                glob_en_i,
  input  logic                cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  input  logic                cmp_we_i,
  input  logic                cmp_hi_i,
  input  logic [NAR_W-1:0]    cmp_wdata_i,
  input  logic                sts_clr_i,
  output logic [2*NAR_W-1:0]  cmp_rd_o,
  output logic [CFG_W-1:0]    cfg_rd_o,
  output logic                stat_set_o,
  output logic                irq_o
);
  localparam int unsigned CNT_W = 2 * NAR_W;

  cfg_t cfg_q, cfg_n, cfg_wr;
  logic [CNT_W-1:0] cmp_q, per_q, tgt_q, due_q;
  logic [CNT_W-1:0] cmp_base, per_base, cmp_n, cmp_put, per_put;
  logic [CNT_W-1:0] calc_tgt, calc_due, rl_tgt, due_gap;
  logic wrap_q, armed_q, glob_q;
  logic calc_wrap, fire, cmp_acc, arm, disarm, reload_go;

  assign cfg_wr  = cfg_t'(cfg_wdata_i);
  assign due_gap = cnt_i - due_q;
  assign fire    = armed_q && glob_en_i && !due_gap[CNT_W-1];
  assign cmp_acc = cmp_we_i && !cfg_we_i && !(cfg_q.w32 && cmp_hi_i);
  assign arm     = glob_en_i && ((cfg_we_i && cfg_wr.en && !cfg_q.en) || cmp_acc || !glob_q);
  assign disarm  = !glob_en_i || (cfg_we_i && !cfg_wr.en && cfg_q.en);
  assign reload_go = fire && !arm && !disarm && !wrap_q && cfg_q.per && (per_q != '0);

  // Half placement of a comparator or period write.
  always_comb begin
    if (cfg_q.w32) begin
      cmp_put = {{NAR_W{1'b0}}, cmp_wdata_i};
      per_put = {{NAR_W{1'b0}}, cmp_wdata_i};
    end else if (cmp_hi_i) begin
      cmp_put = {cmp_wdata_i, cmp_q[NAR_W-1:0]};
      per_put = {cmp_wdata_i, per_q[NAR_W-1:0]};
    end else begin
      cmp_put = {cmp_q[CNT_W-1:NAR_W], cmp_wdata_i};
      per_put = {per_q[CNT_W-1:NAR_W], cmp_wdata_i};
    end
  end

  // Register-interface effects on config, comparator and period.
  always_comb begin
    cfg_n    = cfg_q;
    cmp_base = cmp_q;
    per_base = per_q;
    if (cfg_we_i) begin
      cfg_n = cfg_wr;
      if (cfg_wr.w32) begin
        cmp_base = {{NAR_W{1'b0}}, cmp_q[NAR_W-1:0]};
        per_base = {{NAR_W{1'b0}}, per_q[NAR_W-1:0]};
      end
    end else if (cmp_acc) begin
      if (!cfg_q.per || cfg_q.setval) cmp_base = cmp_put;
      if (cfg_q.per) per_base = per_put;
      cfg_n.setval = 1'b0;
    end
    cmp_n = (reload_go && cfg_q.w32) ? {{NAR_W{1'b0}}, rl_tgt[NAR_W-1:0]} : cmp_base;
  end

  tmr_arm_calc #(.NAR_W(NAR_W)) i_arm (
    .cmp_i (cmp_base),
    .cnt_i (cnt_i),
    .w32_i (cfg_n.w32),
    .per_i (cfg_n.per),
    .tgt_o (calc_tgt),
    .due_o (calc_due),
    .wrap_o(calc_wrap)
  );

  tmr_reload #(.CNT_W(CNT_W)) i_reload (
    .tgt_i(tgt_q),
    .cnt_i(cnt_i),
    .per_i(per_q),
    .tgt_o(rl_tgt)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      cmp_q   <= '0;
      per_q   <= '0;
      tgt_q   <= '0;
      due_q   <= '0;
      wrap_q  <= 1'b0;
      armed_q <= 1'b0;
      glob_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_n;
      cmp_q  <= cmp_n;
      per_q  <= per_base;
      glob_q <= glob_en_i;
      if (disarm) begin
        armed_q <= 1'b0;
        wrap_q  <= 1'b0;
      end else if (arm) begin
        armed_q <= 1'b1;
        tgt_q   <= calc_tgt;
        due_q   <= calc_due;
        wrap_q  <= calc_wrap;
      end else if (fire) begin
        if (wrap_q) begin
          wrap_q <= 1'b0;
          due_q  <= tgt_q;
        end else if (reload_go) begin
          tgt_q <= rl_tgt;
          due_q <= rl_tgt;
        end else begin
          armed_q <= 1'b0;
        end
      end
    end
  end

  tmr_irq_out i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .en_i      (cfg_q.en),
    .level_i   (cfg_q.level),
    .glob_en_i (glob_en_i),
    .clr_i     (sts_clr_i),
    .stat_set_o(stat_set_o),
    .irq_o     (irq_o)
  );

  assign cmp_rd_o = cmp_q;
  assign cfg_rd_o = cfg_q;

  assert_hi_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_we_i && cmp_hi_i && cfg_q.w32 && !cfg_we_i && !reload_go) |=> $stable(cmp_q));

  assert_cmp_narrow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.w32 |-> (cmp_q[CNT_W-1:NAR_W] == '0));

  assert_reload_ahead_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_go |=> ($signed(tgt_q - $past(cnt_i)) > 0));

  assert_wrap_then_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && wrap_q && !arm && !disarm) |=> (armed_q && !wrap_q && (due_q == tgt_q)));

  assert_no_fire_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glob_en_i && !glob_q) |-> !stat_set_o);
endmodule

// File: tb/test_tmr_channel.sv
`timescale 1ns/1ps
module test_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] cnt;
  logic        glob_en, cfg_we, cmp_we, cmp_hi, sts_clr;
  logic [4:0]  cfg_wd;
  logic [31:0] cmp_wd;
  logic [63:0] cmp_rd;
  logic [4:0]  cfg_rd;
  logic        stat_set, irq;

  always #4 clk = ~clk;

  tmr_channel i_tmr_channel (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .glob_en_i(glob_en),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cmp_we_i(cmp_we),
    .cmp_hi_i(cmp_hi), .cmp_wdata_i(cmp_wd), .sts_clr_i(sts_clr),
    .cmp_rd_o(cmp_rd), .cfg_rd_o(cfg_rd), .stat_set_o(stat_set), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  int n_rise = 0, n_hi = 0, n_stat = 0;
  bit irq_prev = 1'b0, finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced at each rising edge.
  logic [4:0]  m_cfg, c_cfg;
  logic [63:0] m_cmp, m_per, m_tgt, m_due, c_cmp, c_per, c_tgt, c_due, t, wp, v, pv;
  logic        m_wrap, m_armed, m_glob, m_stat, m_pulse, m_lvl;
  logic        c_wrap, c_armed, c_lvl, f, acc, armev, dis;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg <= '0; m_cmp <= '0; m_per <= '0; m_tgt <= '0; m_due <= '0;
      m_wrap <= 0; m_armed <= 0; m_glob <= 0; m_stat <= 0; m_pulse <= 0; m_lvl <= 0;
    end else begin
      f = m_armed && glob_en && ($signed(cnt - m_due) >= 0);
      c_cfg = m_cfg; c_cmp = m_cmp; c_per = m_per;
      acc = cmp_we && !cfg_we && !(m_cfg[3] && cmp_hi);
      if (cfg_we) begin
        c_cfg = cfg_wd;
        if (cfg_wd[3]) begin c_cmp = m_cmp & 64'hFFFF_FFFF; c_per = m_per & 64'hFFFF_FFFF; end
      end else if (acc) begin
        if (m_cfg[3]) begin v = {32'h0, cmp_wd}; pv = v; end
        else if (cmp_hi) begin v = {cmp_wd, m_cmp[31:0]}; pv = {cmp_wd, m_per[31:0]}; end
        else begin v = {m_cmp[63:32], cmp_wd}; pv = {m_per[63:32], cmp_wd}; end
        if (!m_cfg[1] || m_cfg[4]) c_cmp = v;
        if (m_cfg[1]) c_per = pv;
        c_cfg[4] = 1'b0;
      end
      armev = glob_en && ((cfg_we && cfg_wd[0] && !m_cfg[0]) || acc || !m_glob);
      dis = !glob_en || (cfg_we && !cfg_wd[0] && m_cfg[0]);
      c_armed = m_armed; c_wrap = m_wrap; c_tgt = m_tgt; c_due = m_due;
      if (dis) begin
        c_armed = 0; c_wrap = 0;
      end else if (armev) begin
        if (c_cfg[3]) begin
          t = (cnt & 64'hFFFF_FFFF_0000_0000) | (c_cmp & 64'hFFFF_FFFF);
          if (t < cnt) t = t + 64'h1_0000_0000;
        end else t = c_cmp;
        wp = (cnt | 64'hFFFF_FFFF) + 1;
        c_armed = 1; c_tgt = t;
        if (c_cfg[3] && !c_cfg[1] && t > wp) begin c_wrap = 1; c_due = wp; end
        else begin c_wrap = 0; c_due = t; end
      end else if (f) begin
        if (m_wrap) begin c_wrap = 0; c_due = m_tgt; end
        else if (m_cfg[1] && m_per != 0) begin
          t = m_tgt;
          do t = t + m_per; while ($signed(t - cnt) <= 0);
          c_tgt = t; c_due = t;
          if (m_cfg[3]) c_cmp = {32'h0, t[31:0]};
        end else c_armed = 0;
      end
      if (f && m_cfg[0] && m_cfg[2]) c_lvl = 1;
      else if (sts_clr || !glob_en || !m_cfg[0] || !m_cfg[2]) c_lvl = 0;
      else c_lvl = m_lvl;
      m_stat <= f && m_cfg[2];
      m_pulse <= f && m_cfg[0] && !m_cfg[2];
      m_lvl <= c_lvl;
      m_cfg <= c_cfg; m_cmp <= c_cmp; m_per <= c_per; m_tgt <= c_tgt; m_due <= c_due;
      m_wrap <= c_wrap; m_armed <= c_armed; m_glob <= glob_en;
    end
  end

  // Per-clock comparison, 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk("R8 irq_o vs model", {63'h0, irq}, {63'h0, m_pulse | m_lvl});
      chk("R7 stat_set_o vs model", {63'h0, stat_set}, {63'h0, m_stat});
      chk("R5 cmp_rd_o vs model", cmp_rd, m_cmp);
      chk("R5 cfg_rd_o vs model", {59'h0, cfg_rd}, {59'h0, m_cfg});
      if (irq && !irq_prev) n_rise++;
      if (irq) n_hi++;
      if (stat_set) n_stat++;
      irq_prev = irq;
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      cnt = cnt + 1; cfg_we = 0; cmp_we = 0; sts_clr = 0;
    end
  endtask
  task automatic wcfg(input logic [4:0] val);
    @(negedge clk);
    cnt = cnt + 1; cfg_we = 1; cfg_wd = val; cmp_we = 0; sts_clr = 0;
    idle(1);
  endtask
  task automatic wcmp(input logic hi, input logic [31:0] d);
    @(negedge clk);
    cnt = cnt + 1; cfg_we = 0; cmp_we = 1; cmp_hi = hi; cmp_wd = d; sts_clr = 0;
    idle(1);
  endtask
  task automatic jump(input logic [63:0] val);
    @(negedge clk);
    cnt = val; cfg_we = 0; cmp_we = 0; sts_clr = 0;
  endtask
  task automatic set_glob(input logic b);
    @(negedge clk);
    cnt = cnt + 1; glob_en = b; cfg_we = 0; cmp_we = 0; sts_clr = 0;
  endtask
  task automatic ack();
    @(negedge clk);
    cnt = cnt + 1; sts_clr = 1; cfg_we = 0; cmp_we = 0;
    idle(1);
  endtask
  task automatic clr_counts();
    n_rise = 0; n_hi = 0; n_stat = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; cnt = 0; glob_en = 0; cfg_we = 0; cfg_wd = 0;
    cmp_we = 0; cmp_hi = 0; cmp_wd = 0; sts_clr = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset irq_o", {63'h0, irq}, 64'h0);
    chk("R7 reset stat_set_o", {63'h0, stat_set}, 64'h0);
    chk("R5 reset cfg_rd_o", {59'h0, cfg_rd}, 64'h0);
    rst_n = 1;

    // R2/R8: 64-bit one-shot, edge mode
    jump(64'd1000);
    set_glob(1);
    wcmp(1, 32'h0);
    wcmp(0, 32'd1060);
    chk("R2 comparator readback", cmp_rd, 64'd1060);
    wcfg(5'b00001);
    clr_counts();
    idle(80);
    chk("R2 one-shot fires once", n_rise, 1);
    chk("R8 edge pulse is one cycle", n_hi, 1);
    chk("R7 edge mode sets no status", n_stat, 0);

    // R3/R1: 32-bit one-shot across a wrap
    wcfg(5'b00000);
    jump(64'h1_FFFF_FF00);
    wcfg(5'b01000);
    wcmp(0, 32'h20);
    wcfg(5'b01001);
    clr_counts();
    idle(320);
    chk("R3 wrap fire plus target fire", n_rise, 2);
    wcfg(5'b00000);
    jump(64'h3_0000_0010);
    wcfg(5'b01000);
    wcmp(0, 32'h40);
    wcfg(5'b01001);
    clr_counts();
    idle(100);
    chk("R1 placed target without wrap fires once", n_rise, 1);

    // R4/R5: periodic 32-bit with skip
    wcfg(5'b00000);
    jump(64'd10);
    wcfg(5'b11010);
    wcmp(0, 32'd50);
    chk("R5 set-value clears after write", {59'h0, cfg_rd}, 64'b01010);
    chk("R5 set-value lets comparator load", cmp_rd, 64'd50);
    wcfg(5'b01011);
    clr_counts();
    idle(45);
    chk("R4 periodic reload moves comparator", cmp_rd, 64'd100);
    jump(64'd390);
    idle(2);
    chk("R4 missed periods skipped", cmp_rd, 64'd400);
    wcmp(0, 32'd30);
    chk("R5 periodic write without set-value keeps comparator", cmp_rd, 64'd400);
    idle(20);
    chk("R5 period register took written value", cmp_rd, 64'd430);
    chk("R8 periodic fires counted", n_rise, 3);

    // R7/R11: level mode
    wcfg(5'b00000);
    jump(64'd5000);
    wcfg(5'b00100);
    wcmp(1, 32'h0);
    wcmp(0, 32'd5020);
    clr_counts();
    idle(40);
    chk("R7 status set with channel disabled", n_stat, 1);
    chk("R8 no irq with channel disabled", n_hi, 0);
    wcfg(5'b00101);
    idle(5);
    chk("R11 level irq held", {63'h0, irq}, 64'h1);
    ack();
    chk("R11 level irq dropped by status clear", {63'h0, irq}, 64'h0);

    // R6: narrow mode comparator halves
    wcfg(5'b00000);
    wcmp(1, 32'hABCD);
    chk("R6 upper half written in 64-bit mode", {32'h0, cmp_rd[63:32]}, 64'hABCD);
    wcfg(5'b01000);
    chk("R6 entering 32-bit mode truncates", {32'h0, cmp_rd[63:32]}, 64'h0);
    wcmp(1, 32'h1234);
    chk("R6 upper write ignored in 32-bit mode", cmp_rd, 64'd5020);

    // R10: global enable
    wcfg(5'b00000);
    wcmp(1, cnt[63:32]);
    wcmp(0, cnt[31:0] + 32'd40);
    wcfg(5'b00001);
    set_glob(0);
    clr_counts();
    idle(80);
    chk("R10 nothing fires while globally disabled", n_rise, 0);
    set_glob(1);
    idle(4);
    chk("R10 global enable re-arms and fires", n_rise, 1);

    // R9: re-arm clears the pending wrap firing
    wcfg(5'b00000);
    jump(64'h5_FFFF_FF00);
    wcfg(5'b01000);
    wcmp(0, 32'h20);
    wcfg(5'b01001);
    wcmp(0, 32'hFFFF_FF40);
    clr_counts();
    idle(300);
    chk("R9 re-arm dropped wrap firing", n_rise, 1);

    idle(2);
    finish_run();
  end
endmodule